// File: doc/BRIEF.md
# VT1.5 Path Overhead Byte Monitor

This block watches the byte stream of one VT1.5 path and checks the path overhead byte that opens every VT superframe. Over all bytes of a superframe it builds a two-bit interleaved parity. It compares that parity with the parity field carried in the next overhead byte, and it accumulates the number of mismatching bits in a saturating counter. It also counts the remote error indications carried in the overhead byte. The three-bit signal label and the single-bit remote defect flag pass through persistence filters, so that a new value is only accepted once it has been seen in enough consecutive superframes. The accepted label drives an unequipped alarm and a label mismatch alarm against a label supplied from outside.

Upstream logic delivers the overhead byte and the payload bytes of the path, with the pointer bytes already removed, as one beat per byte. `in_v5` marks the overhead byte. The stream interface is valid/ready, but the monitor never applies back-pressure: `in_ready` is held high and a byte is taken on every cycle where `in_valid` is high. Beats with `in_valid` low carry nothing. The block does not check the superframe length. The overhead byte layout it uses, from most to least significant bit, is: parity bits 1 and 2 in [7:6], remote error in [5], remote failure in [4] (not used), signal label in [3:1], and remote defect in [0].

Top module: `v5_path_monitor`

## Requirements
- R1: `in_ready` is 1 in every cycle, including during reset, and a byte is consumed on each clock edge where `in_valid` is 1.
- R2: Parity bit 1 is the XOR of data bits 7, 5, 3 and 1, and parity bit 2 is the XOR of bits 6, 4, 2 and 0, taken over every byte from one overhead byte up to the byte before the next one. At each overhead byte after the first one since reset, the number of differing bits between this parity and bits [7:6] of the new overhead byte (0, 1 or 2) is added to `bip_err_cnt` at that clock edge.
- R3: `bip_err_cnt` saturates at 2^CNT_W-1 and never wraps.
- R4: `rei_cnt` increases by one at each overhead byte with bit 5 set, and saturates at 2^CNT_W-1.
- R5: A label value in bits [3:1] becomes `label_now` at the clock edge of the PERSIST-th consecutive overhead byte carrying it. A different value in between restarts the run. `label_known` rises with the first accepted label.
- R6: `uneq_alarm` is 1 exactly when `label_known` is 1 and the accepted label is 000.
- R7: `slm_alarm` is 1 exactly when `label_known` is 1, the accepted label is neither 000 nor 001, and it differs from `exp_label`. A change of `exp_label` takes effect in the same cycle.
- R8: An accepted label of 001 never raises `slm_alarm`, whatever `exp_label` holds.
- R9: `rdi_alarm` takes the value of bit 0 at the clock edge of the PERSIST-th consecutive overhead byte with that value, both when it sets and when it clears.
- R10: After reset, both counters are 0, `label_now` is 000, and `label_known`, `slm_alarm`, `uneq_alarm` and `rdi_alarm` are 0.
- R11: A cycle with `in_valid` low changes no parity, counter or filter state, even when `in_v5` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte is present on `in_data` |
| in_ready | output | 1 | Always 1; the monitor never stalls |
| in_data | input | 8 | Path byte |
| in_v5 | input | 1 | Marks the overhead byte that opens a superframe |
| exp_label | input | 3 | Expected signal label |
| bip_err_cnt | output | CNT_W | Saturating count of parity bit errors |
| rei_cnt | output | CNT_W | Saturating count of remote error indications |
| label_now | output | 3 | Accepted signal label |
| label_known | output | 1 | A label has been accepted since reset |
| slm_alarm | output | 1 | Label mismatch |
| uneq_alarm | output | 1 | Path unequipped |
| rdi_alarm | output | 1 | Accepted remote defect indication |

## Verification
The hardest condition to reach from the ports is a persistence run that is broken just before it completes. For example, four superframes carry one label, one superframe carries another, and four more carry the first again. Only a correctly restarted run keeps the old label in place. The bench drives whole superframes from a table of label, defect and error-mask values. It writes the parity field of each overhead byte as the parity it has computed itself, XOR a chosen mask, so each error count from 0 to 2 is produced deliberately. It also places invalid beats carrying a marker and all-ones data inside superframes. Every label is swept through acceptance and then checked against every expected label.

// File: rtl/v5mon_pkg.sv
package v5mon_pkg;
  localparam int BIP_HI  = 7;
  localparam int BIP_LO  = 6;
  localparam int REI_BIT = 5;
  localparam int LBL_HI  = 3;
  localparam int LBL_LO  = 1;
  localparam int RDI_BIT = 0;
  localparam int LBL_W   = LBL_HI - LBL_LO + 1;

  localparam logic [LBL_W-1:0] LBL_UNEQ    = 3'b000;
  localparam logic [LBL_W-1:0] LBL_GENERIC = 3'b001;

  // Interleaved two-bit parity of one byte: [1] covers bits 7,5,3,1; [0] covers 6,4,2,0.
  function automatic logic [1:0] byte_bip2(input logic [7:0] b);
    logic [1:0] p;
    p = 2'b00;
    for (int i = 0; i < 8; i += 2) begin
      p[0] = p[0] ^ b[i];
      p[1] = p[1] ^ b[i+1];
    end
    return p;
  endfunction
endpackage

// File: rtl/v5mon_bip_acc.sv
module v5mon_bip_acc
  import v5mon_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       beat,
  input  logic       mark,
  input  logic [7:0] data,
  output logic [1:0] err_bits
);
  logic [1:0] par_q;
  logic       have_prev_q;
  logic [1:0] diff;

  assign diff     = par_q ^ data[BIP_HI:BIP_LO];
  assign err_bits = (beat && mark && have_prev_q) ? (2'(diff[0]) + 2'(diff[1])) : 2'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      par_q       <= 2'b00;
      have_prev_q <= 1'b0;
    end else if (beat) begin
      if (mark) begin
        par_q       <= byte_bip2(data);
        have_prev_q <= 1'b1;
      end else begin
        par_q <= par_q ^ byte_bip2(data);
      end
    end
  end

  // R2: no error can be reported before a previous superframe exists
  p_first_frame_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !have_prev_q |-> err_bits == 2'd0);
  // R11: idle cycles leave the running parity alone
  p_idle_keeps_parity_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !beat |=> $stable(par_q));
endmodule

// File: rtl/v5mon_sat_cnt.sv
module v5mon_sat_cnt #(
  parameter int W     = 16,
  parameter int INC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INC_W-1:0] inc,
  output logic [W-1:0]     count
);
  localparam int          SUM_W = W + 1;
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [SUM_W-1:0] sum;
  assign sum = {1'b0, count} + SUM_W'(inc);

  always_ff @(posedge clk) begin
    if (!rst_n)           count <= '0;
    else if (sum[W])      count <= MAXV;
    else                  count <= sum[W-1:0];
  end

  // R3: a saturating counter never moves down
  p_never_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count >= $past(count));
  // R3: once at the top it stays there
  p_sat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count == MAXV |=> count == MAXV);
endmodule

// File: rtl/v5mon_persist.sv
module v5mon_persist #(
  parameter int W       = 3,
  parameter int PERSIST = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe,
  input  logic [W-1:0] sample,
  output logic [W-1:0] value,
  output logic         known
);
  localparam int RUN_W = $clog2(PERSIST + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(PERSIST);

  logic [W-1:0]     cand_q;
  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] run_nxt;

  always_comb begin
    if (sample != cand_q)      run_nxt = RUN_W'(1);
    else if (run_q == RUN_MAX) run_nxt = RUN_MAX;
    else                       run_nxt = run_q + RUN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cand_q <= '0;
      run_q  <= '0;
      value  <= '0;
      known  <= 1'b0;
    end else if (strobe) begin
      cand_q <= sample;
      run_q  <= run_nxt;
      if (run_nxt == RUN_MAX) begin
        value <= sample;
        known <= 1'b1;
      end
    end
  end

  // R5, R9: the accepted value only moves on an overhead byte
  p_hold_between_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(value));
  // R5, R9: a new accepted value equals the sample that completed the run
  p_value_from_sample_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && (run_nxt == RUN_MAX) |=> value == $past(sample));
endmodule

// File: rtl/v5_path_monitor.sv
module v5_path_monitor
  import v5mon_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PERSIST = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_v5,
  input  logic [2:0]       exp_label,
  output logic [CNT_W-1:0] bip_err_cnt,
  output logic [CNT_W-1:0] rei_cnt,
  output logic [2:0]       label_now,
  output logic             label_known,
  output logic             slm_alarm,
  output logic             uneq_alarm,
  output logic             rdi_alarm
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic       beat;
  logic       ovh;
  logic [1:0] bip_inc;
  logic [0:0] rei_inc;
  logic       rdi_known;

  assign in_ready = 1'b1;
  assign beat     = in_valid && in_ready;
  assign ovh      = beat && in_v5;
  assign rei_inc  = ovh && in_data[REI_BIT];

  v5mon_bip_acc u_bip (
    .clk      (clk),
    .rst_n    (rst_n),
    .beat     (beat),
    .mark     (in_v5),
    .data     (in_data),
    .err_bits (bip_inc)
  );

  v5mon_sat_cnt #(.W(CNT_W), .INC_W(2)) u_bip_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (bip_inc),
    .count (bip_err_cnt)
  );

  v5mon_sat_cnt #(.W(CNT_W), .INC_W(1)) u_rei_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (rei_inc),
    .count (rei_cnt)
  );

  v5mon_persist #(.W(LBL_W), .PERSIST(PERSIST)) u_label (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (ovh),
    .sample (in_data[LBL_HI:LBL_LO]),
    .value  (label_now),
    .known  (label_known)
  );

  v5mon_persist #(.W(1), .PERSIST(PERSIST)) u_rdi (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (ovh),
    .sample (in_data[RDI_BIT]),
    .value  (rdi_alarm),
    .known  (rdi_known)
  );

  assign uneq_alarm = label_known && (label_now == LBL_UNEQ);
  assign slm_alarm  = label_known && (label_now != LBL_UNEQ) &&
                      (label_now != LBL_GENERIC) && (label_now != exp_label);

  // R1: the monitor never stalls the stream
  p_always_ready_r1: assert property (@(posedge clk) in_ready);
  // R6, R7: a path cannot be both unequipped and mismatched
  p_alarm_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(slm_alarm && uneq_alarm));
  // R4: each marked byte with the remote error bit adds exactly one below the top
  p_rei_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovh && in_data[REI_BIT] && rei_cnt != CNT_MAX) |=> rei_cnt == $past(rei_cnt) + 1'b1);
  // R11: without a valid overhead byte neither counter moves
  p_idle_counters_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ovh |=> $stable(bip_err_cnt) && $stable(rei_cnt));
  // R8: a generic label never mismatches
  p_generic_no_slm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (label_now == LBL_GENERIC) |-> !slm_alarm);
endmodule

// File: tb/v5_path_monitor_bench.sv
module v5_path_monitor_bench;
  localparam int CW   = 4;
  localparam int PS   = 5;
  localparam int MAXC = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [7:0]    in_data = 8'h00;
  logic          in_v5 = 1'b0;
  logic [2:0]    exp_label = 3'd2;
  logic [CW-1:0] bip_err_cnt, rei_cnt;
  logic [2:0]    label_now;
  logic          label_known, slm_alarm, uneq_alarm, rdi_alarm;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // model state
  logic [1:0] m_par = 2'b00;
  bit m_have = 0;
  int m_bip = 0, m_rei = 0;
  int l_cand = 0, l_run = 0, l_acc = 0; bit l_known = 0;
  int r_cand = 0, r_run = 0, r_acc = 0;
  int sf_no = 0;

  always #10 clk = ~clk;

  v5_path_monitor #(.CNT_W(CW), .PERSIST(PS)) u_v5_path_monitor (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_v5(in_v5), .exp_label(exp_label),
    .bip_err_cnt(bip_err_cnt), .rei_cnt(rei_cnt), .label_now(label_now),
    .label_known(label_known), .slm_alarm(slm_alarm), .uneq_alarm(uneq_alarm),
    .rdi_alarm(rdi_alarm)
  );

  task automatic chk(input string rq, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (sf %0d)", rq, act, exp, sf_no);
    end
  endtask

  function automatic logic [1:0] par8(input logic [7:0] b);
    return {b[7] ^ b[5] ^ b[3] ^ b[1], b[6] ^ b[4] ^ b[2] ^ b[0]};
  endfunction

  function automatic int sat(input int x);
    return (x > MAXC) ? MAXC : x;
  endfunction

  function automatic int exp_slm();
    return (l_known && l_acc > 1 && l_acc != int'(exp_label)) ? 1 : 0;
  endfunction

  task automatic beat(input logic v, input logic m, input logic [7:0] d);
    @(negedge clk);
    in_valid = v; in_v5 = m; in_data = d;
  endtask

  task automatic check_all();
    chk("R2_R3_R11 bip count", int'(bip_err_cnt), m_bip);
    chk("R4 rei count", int'(rei_cnt), m_rei);
    chk("R5 label", int'(label_now), l_acc);
    chk("R5 label known", int'(label_known), int'(l_known));
    chk("R6 unequipped", int'(uneq_alarm), (l_known && l_acc == 0) ? 1 : 0);
    chk("R7_R8 mismatch", int'(slm_alarm), exp_slm());
    chk("R9 rdi", int'(rdi_alarm), r_acc);
  endtask

  // one superframe: overhead byte, then npay payload bytes, optional invalid beat inside
  task automatic do_sf(input int lbl, input int rdi, input int rei, input int mask,
                       input int npay, input bit glitch);
    logic [7:0] v5;
    int pop;
    sf_no++;
    v5 = {m_par ^ 2'(mask), 1'(rei), 1'b0, 3'(lbl), 1'(rdi)};
    pop = (mask & 1) + ((mask >> 1) & 1);
    if (m_have) m_bip = sat(m_bip + pop);
    m_have = 1;
    if (rei != 0) m_rei = sat(m_rei + 1);
    if (lbl == l_cand) l_run = (l_run < PS) ? l_run + 1 : PS; else begin l_cand = lbl; l_run = 1; end
    if (l_run == PS) begin l_acc = l_cand; l_known = 1; end
    if (rdi == r_cand) r_run = (r_run < PS) ? r_run + 1 : PS; else begin r_cand = rdi; r_run = 1; end
    if (r_run == PS) r_acc = r_cand;
    m_par = par8(v5);
    beat(1'b1, 1'b1, v5);
    beat(1'b0, 1'b0, 8'h00);
    check_all();
    for (int k = 0; k < npay; k++) begin
      logic [7:0] d;
      d = 8'((sf_no * 37 + k * 11 + 5) & 255);
      if (glitch && k == 1) beat(1'b0, 1'b1, 8'hFF);
      beat(1'b1, 1'b0, d);
      m_par = m_par ^ par8(d);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 / R10: reset state
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 bip count", int'(bip_err_cnt), 0);
    chk("R10 rei count", int'(rei_cnt), 0);
    chk("R10 label", int'(label_now), 0);
    chk("R10 known", int'(label_known), 0);
    chk("R10 flags", int'({slm_alarm, uneq_alarm, rdi_alarm}), 0);
    chk("R1 ready", int'(in_ready), 1);

    // R2/R3/R4/R11: error masks cycling 0..3, invalid beats in every other frame
    for (int i = 0; i < 16; i++)
      do_sf(2, 0, (i % 3 != 0) ? 1 : 0, i % 4, 3 + (i % 4), (i % 2) == 1);
    chk("R3 bip saturated", int'(bip_err_cnt), MAXC);

    // R5-R8: sweep every label to acceptance, then every expected label
    for (int l = 0; l < 8; l++) begin
      for (int n = 0; n < PS; n++) do_sf(l, 0, 1, 0, 2, 1'b0);
      for (int e = 0; e < 8; e++) begin
        @(negedge clk);
        exp_label = 3'(e);
        #1;
        chk("R7 mismatch vs expected", int'(slm_alarm), exp_slm());
        chk("R6 unequipped vs expected", int'(uneq_alarm), (l == 0) ? 1 : 0);
        if (l == 1) chk("R8 generic label", int'(slm_alarm), 0);
      end
    end
    exp_label = 3'd7;
    chk("R4 rei saturated", int'(rei_cnt), MAXC);

    // R5: interrupted run keeps old label (7), then completes
    for (int n = 0; n < PS - 1; n++) do_sf(3, 0, 0, 1, 2, 1'b0);
    do_sf(6, 0, 0, 0, 2, 1'b0);
    for (int n = 0; n < PS - 1; n++) do_sf(3, 0, 0, 2, 2, 1'b1);
    chk("R5 interrupted run holds", int'(label_now), 7);
    do_sf(3, 0, 0, 0, 2, 1'b0);
    chk("R5 run completes", int'(label_now), 3);

    // R9: set, broken clear, then clear
    for (int n = 0; n < PS; n++) do_sf(3, 1, 0, 0, 2, 1'b0);
    chk("R9 rdi set", int'(rdi_alarm), 1);
    for (int n = 0; n < PS - 1; n++) do_sf(3, 0, 0, 0, 2, 1'b0);
    do_sf(3, 1, 0, 0, 2, 1'b0);
    chk("R9 rdi held after broken run", int'(rdi_alarm), 1);
    for (int n = 0; n < PS; n++) do_sf(3, 0, 0, 0, 2, 1'b1);
    chk("R9 rdi cleared", int'(rdi_alarm), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule